// File: doc/BRIEF.md
# PCI Bridge Secondary Address-Parity Checker

This block watches the address phases that arrive on the secondary side of a PCI-to-PCI bridge. It checks their parity and, when a transaction's addressing is complete, tells the target logic whether it may claim the cycle. A single-address cycle has one address phase and a dual-address cycle (DAC) has two. On a parity error the block can pulse the primary-side system-error line. It keeps four sticky status bits: two error-status flags and two interrupt-status flags. The control enables and interrupt masks decide which of these outputs respond to an error.

The block also generates the address parity that the bridge drives when it forwards a transaction upstream. If the transaction being forwarded had an address parity error, every forwarded parity bit is inverted. This covers both PAR and PAR64 and both DAC phases. The error therefore cannot vanish when the bridge narrows a 64-bit address transfer into 32-bit phases.

Top module: `pci_addr_perr`

## Requirements
- R1: Parity is even. PAR covers `ap_ad[31:0]` and `ap_cbe_n[3:0]`, and PAR64 covers `ap_ad[63:32]` and `ap_cbe_n[7:4]`. Each is presented in the cycle after its address phase. PAR64 is checked only when `ap_wide` is 1. A mismatch on any checked part of either DAC phase makes the transaction errored.
- R2: `dec_valid` is high for exactly one cycle, starting one clock after the parity cycle of the phase flagged by `ap_last`.
- R3: When the transaction is errored and `sec_perr_resp_en` is 1, `dec_block` is 1 together with `dec_valid`, and the bridge must not claim the cycle.
- R4: When `sec_perr_resp_en` is 0, an address parity error leaves `dec_block` at 0.
- R5: `serr_n` goes low for one cycle, together with `dec_valid`, only for an errored transaction in which `cmd_serr_en`, `sec_perr_resp_en` and `sec_serr_en` are all 1.
- R6: `status[0]` (system error signalled) is set at the decision for an errored transaction in which `cmd_serr_en` and `sec_perr_resp_en` are both 1.
- R7: `status[1]` (detected parity error) is set at the decision for every errored transaction, whatever the enables are.
- R8: `status[2]` becomes 1 one clock after `status[0]` is 1 while `mask_pserr` is 0. `status[3]` becomes 1 one clock after `status[1]` is 1 while `mask_sdpe` is 0.
- R9: The status bits are sticky. Writing a 1 to `sts_clr[i]` clears `status[i]` at the next clock. If a set condition occurs in the same clock as the clear, the set wins.
- R10: `fwd_par` and `fwd_par64` show the even parity of the low and high halves of `fwd_ad`/`fwd_cbe_n`, one clock after `fwd_valid`. Both are inverted from the decision of an errored transaction until the clock on which `fwd_end` is 1.
- R11: After reset, `serr_n` is 1 and `dec_valid`, `dec_block`, `status`, `fwd_par` and `fwd_par64` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ap_valid | input | 1 | Address phase present this cycle |
| ap_last | input | 1 | Final address phase of the transaction |
| ap_wide | input | 1 | Upper half is carried, so PAR64 is checked |
| ap_ad | input | 64 | Address bus |
| ap_cbe_n | input | 8 | Command/byte-enable bus |
| par | input | 1 | Parity for the low half, one cycle late |
| par64 | input | 1 | Parity for the high half, one cycle late |
| cmd_serr_en | input | 1 | Primary command system-error enable |
| sec_perr_resp_en | input | 1 | Secondary parity-error response enable |
| sec_serr_en | input | 1 | Secondary system-error forwarding enable |
| mask_pserr | input | 1 | Masks `status[2]` |
| mask_sdpe | input | 1 | Masks `status[3]` |
| sts_clr | input | 4 | Write-one-to-clear strobes for `status` |
| dec_valid | output | 1 | Claim decision pulse |
| dec_block | output | 1 | Do not claim the transaction |
| serr_n | output | 1 | Active-low system-error pulse |
| status | output | 4 | {sdpe irq, pserr irq, detected perr, signalled serr} |
| fwd_valid | input | 1 | Forwarded address phase present |
| fwd_ad | input | 64 | Forwarded address |
| fwd_cbe_n | input | 8 | Forwarded command/byte enables |
| fwd_end | input | 1 | Forwarding of the transaction is finished |
| fwd_par | output | 1 | Forwarded low-half parity |
| fwd_par64 | output | 1 | Forwarded high-half parity |

## Verification
The assertions assume well-formed inputs. A transaction is a run of one or two back-to-back address phases, and only its last phase carries `ap_last`. Each phase's parity arrives in the following cycle, and forwarding of a transaction begins only after its decision. The bench builds every transaction in that shape, with random addresses, widths, enables, masks and corrupted parity parts. It forwards each transaction and closes it with `fwd_end` before the next one starts. Status clears are issued in two cycles, error-status bits first and then interrupt bits, so that the bench's expected values stay exact.

// File: rtl/pci_addr_perr.sv
module pci_addr_perr #(
  parameter int AD_W = 64,
  parameter int BE_W = AD_W / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ap_valid,
  input  logic            ap_last,
  input  logic            ap_wide,
  input  logic [AD_W-1:0] ap_ad,
  input  logic [BE_W-1:0] ap_cbe_n,
  input  logic            par,
  input  logic            par64,
  input  logic            cmd_serr_en,
  input  logic            sec_perr_resp_en,
  input  logic            sec_serr_en,
  input  logic            mask_pserr,
  input  logic            mask_sdpe,
  input  logic [3:0]      sts_clr,
  output logic            dec_valid,
  output logic            dec_block,
  output logic            serr_n,
  output logic [3:0]      status,
  input  logic            fwd_valid,
  input  logic [AD_W-1:0] fwd_ad,
  input  logic [BE_W-1:0] fwd_cbe_n,
  input  logic            fwd_end,
  output logic            fwd_par,
  output logic            fwd_par64
);
  localparam int HA = AD_W / 2;
  localparam int HB = BE_W / 2;

  function automatic logic [1:0] even_par(input logic [AD_W-1:0] ad, input logic [BE_W-1:0] be);
    return {^{ad[AD_W-1:HA], be[BE_W-1:HB]}, ^{ad[HA-1:0], be[HB-1:0]}};
  endfunction

  logic       chk, last, wide, err_acc, corrupt;
  logic [1:0] exp_par;

  wire err_ph  = chk && ((par ^ exp_par[0]) || (wide && (par64 ^ exp_par[1])));
  wire err_tot = err_acc || err_ph;
  wire done    = chk && last;
  wire hit     = done && err_tot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk       <= 1'b0;
      last      <= 1'b0;
      wide      <= 1'b0;
      exp_par   <= 2'b00;
      err_acc   <= 1'b0;
      corrupt   <= 1'b0;
      dec_valid <= 1'b0;
      dec_block <= 1'b0;
      serr_n    <= 1'b1;
      status    <= 4'b0000;
      fwd_par   <= 1'b0;
      fwd_par64 <= 1'b0;
    end else begin
      chk <= ap_valid;
      if (ap_valid) begin
        last    <= ap_last;
        wide    <= ap_wide;
        exp_par <= even_par(ap_ad, ap_cbe_n);
      end
      if (done)     err_acc <= 1'b0;
      else if (chk) err_acc <= err_tot;
      dec_valid <= done;
      dec_block <= hit && sec_perr_resp_en;
      serr_n    <= !(hit && cmd_serr_en && sec_perr_resp_en && sec_serr_en);
      status[0] <= (status[0] && !sts_clr[0]) || (hit && cmd_serr_en && sec_perr_resp_en);
      status[1] <= (status[1] && !sts_clr[1]) || hit;
      status[2] <= (status[2] && !sts_clr[2]) || (status[0] && !mask_pserr);
      status[3] <= (status[3] && !sts_clr[3]) || (status[1] && !mask_sdpe);
      corrupt   <= (corrupt && !fwd_end) || hit;
      if (fwd_valid)
        {fwd_par64, fwd_par} <= even_par(fwd_ad, fwd_cbe_n) ^ {2{corrupt}};
    end
  end

  // R5
  serr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> (dec_valid && dec_block && status[0] && status[1]));

  // R3
  block_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_block |-> (dec_valid && status[1]));

  // R9
  sticky_dpe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !sts_clr[1]) |=> status[1]);

  // R8
  pserr_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(status[0] && !mask_pserr));

  // R8
  sdpe_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> $past(status[1] && !mask_sdpe));
endmodule

// File: tb/tb_pci_addr_perr.sv
module tb_pci_addr_perr;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, ap_valid, ap_last, ap_wide, par, par64;
  logic [63:0] ap_ad, fwd_ad;
  logic [7:0]  ap_cbe_n, fwd_cbe_n;
  logic        cmd_serr_en, sec_perr_resp_en, sec_serr_en, mask_pserr, mask_sdpe;
  logic [3:0]  sts_clr, status;
  logic        dec_valid, dec_block, serr_n, fwd_valid, fwd_end, fwd_par, fwd_par64;

  pci_addr_perr dut (.*);

  int checks = 0, fails = 0;
  logic [3:0] m_st;
  logic       m_corrupt;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] epar(logic [63:0] ad, logic [7:0] be);
    return {^{ad[63:32], be[7:4]}, ^{ad[31:0], be[3:0]}};
  endfunction

  task automatic forward_phase();
    logic [63:0] a = {$urandom, $urandom};
    logic [7:0]  c = 8'($urandom);
    @(negedge clk); fwd_valid = 1; fwd_ad = a; fwd_cbe_n = c;
    @(negedge clk); fwd_valid = 0;
    check("R10 fwd_par", fwd_par, epar(a, c)[0] ^ m_corrupt);
    check("R10 fwd_par64", fwd_par64, epar(a, c)[1] ^ m_corrupt);
  endtask

  // bad: [0] ph1 PAR, [1] ph1 PAR64, [2] ph2 PAR, [3] ph2 PAR64
  task automatic run_txn(bit dac, bit wide, logic [3:0] bad, bit hold_clr1);
    logic [63:0] a1 = {$urandom, $urandom}, a2 = {$urandom, $urandom};
    logic [7:0]  c1 = 8'($urandom), c2 = 8'($urandom);
    logic [1:0]  p1 = epar(a1, c1), p2 = epar(a2, c2);
    bit err = bad[0] | (wide & bad[1]) | (dac & (bad[2] | (wide & bad[3])));
    bit all3 = cmd_serr_en & sec_perr_resp_en & sec_serr_en;
    @(negedge clk);
    if (hold_clr1) sts_clr = 4'b0010;
    ap_valid = 1; ap_ad = a1; ap_cbe_n = c1; ap_last = !dac; ap_wide = wide;
    @(negedge clk);
    par = p1[0] ^ bad[0]; par64 = p1[1] ^ bad[1];
    if (dac) begin ap_ad = a2; ap_cbe_n = c2; ap_last = 1; end
    else ap_valid = 0;
    if (dac) begin
      @(negedge clk);
      ap_valid = 0; par = p2[0] ^ bad[2]; par64 = p2[1] ^ bad[3];
    end
    @(negedge clk);
    par = 0; par64 = 0;
    if (hold_clr1) m_st[1] = 1'b0;
    m_st[0] = m_st[0] | (err & cmd_serr_en & sec_perr_resp_en);
    m_st[1] = m_st[1] | err;
    check("R2 dec_valid", dec_valid, 1);
    check(sec_perr_resp_en ? "R3 dec_block" : "R4 dec_block", dec_block, err & sec_perr_resp_en);
    check("R5 serr_n", serr_n, !(err & all3));
    check("R6 status0", status[0], m_st[0]);
    check(hold_clr1 ? "R9 set wins" : "R7 status1", status[1], m_st[1]);
    sts_clr = 4'b0000;
    @(negedge clk);
    m_st[2] = m_st[2] | (m_st[0] & !mask_pserr);
    m_st[3] = m_st[3] | (m_st[1] & !mask_sdpe);
    check("R8 status", status, m_st);
    check("R2 pulse", dec_valid, 0);
    check("R5 pulse", serr_n, 1);
    m_corrupt = err;
    forward_phase();
    if (dac) forward_phase();
    @(negedge clk); fwd_end = 1;
    @(negedge clk); fwd_end = 0;
    m_corrupt = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); sts_clr = 4'b0011;
    @(negedge clk); sts_clr = 4'b1100;
    @(negedge clk); sts_clr = 4'b0000;
    m_st = 4'b0000;
    check("R9 cleared", status, 4'b0000);
  endtask

  task automatic set_cfg(logic [4:0] v);
    {cmd_serr_en, sec_perr_resp_en, sec_serr_en, mask_pserr, mask_sdpe} = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; ap_valid = 0; ap_last = 0; ap_wide = 0; ap_ad = '0; ap_cbe_n = '0;
    par = 0; par64 = 0; sts_clr = 0; fwd_valid = 0; fwd_ad = '0; fwd_cbe_n = '0; fwd_end = 0;
    set_cfg(5'b00011);
    m_st = 0; m_corrupt = 0;
    repeat (3) @(negedge clk);
    check("R11 serr_n", serr_n, 1);
    check("R11 status", status, 0);
    check("R11 dec", {dec_valid, dec_block}, 0);
    check("R11 fwd", {fwd_par, fwd_par64}, 0);
    rst_n = 1;

    set_cfg(5'b11100); run_txn(0, 0, 4'b0001, 0);   // R1 single PAR error, all enables
    clear_all();
    set_cfg(5'b11111); run_txn(0, 0, 4'b0010, 0);   // R1 PAR64 ignored when narrow
    set_cfg(5'b11111); run_txn(1, 1, 4'b1000, 0);   // R1 DAC second-phase PAR64 error
    clear_all();
    set_cfg(5'b10100); run_txn(1, 0, 4'b0100, 0);   // R4 no response enable
    set_cfg(5'b11011); run_txn(1, 1, 4'b0000, 0);   // R9 sticky across clean txn
    clear_all();
    set_cfg(5'b01011); run_txn(0, 1, 4'b0001, 1);   // R9 set beats clear
    clear_all();

    for (int i = 0; i < 400; i++) begin
      set_cfg(5'($urandom));
      run_txn(1'($urandom), 1'($urandom), ($urandom % 3 == 0) ? 4'($urandom) : 4'b0000, 0);
      if ($urandom % 4 == 0) clear_all();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule